// File: doc/BRIEF.md
# Address-Range Steering Classifier

The classifier decides how a register access that targets a replicated register must be routed. It receives a register address and answers with three things. The first is a steer flag. The second is a group/instance pair that selects which copy of the register to use. The third is a pair of warning flags. The answer comes from a set of steering classes. Each normal class owns a short list of inclusive address ranges and a programmed group/instance target. One extra class, the implicit class, lists addresses that need no steering at all.

A lookup walks the classes from index 0 upward, and then the implicit class, visiting one range entry per clock. In each class the first entry whose upper bound is zero closes that class's list. The first range that contains the address decides the answer. If nothing matches, the block still answers with a steered 0/0 result and raises a warning. Software, or a set-up sequencer, loads the ranges and targets through a configuration port while the engine is idle. A per-class "initialized" flag lets the block warn when a target is used before it has been chosen.

Top module: `steer_classifier`

## Requirements
- R1: During and right after reset, req_ready is 1, rsp_valid is 0, and rsp_steer, rsp_group, rsp_inst and both warning flags are 0. All range entries are empty (upper bound 0).
- R2: Normal classes are searched in increasing index order. The first class that holds a range containing the address supplies its group and instance, with rsp_steer = 1.
- R3: A range matches an address A when lo <= A <= hi. Both bounds are inclusive, so lo-1 and hi+1 do not match.
- R4: In each class, the list ends at the first entry (slot 0 upward) whose upper bound is 0. Entries after it are never matched.
- R5: A class whose slot-0 upper bound is 0 has no ranges and is skipped.
- R6: The implicit class has index NUM_CLASSES on the range-configuration port. It is searched only after every normal class has missed. A hit there returns rsp_steer = 0, group 0, instance 0, and no warning.
- R7: When no range in any class matches, the response is rsp_steer = 1, group 0, instance 0, with rsp_warn_notfound = 1.
- R8: A hit in normal class c while cls_init[c] = 0 still returns that class's target, and also sets rsp_warn_uninit = 1.
- R9: A request is accepted only at a clock edge where req_valid and req_ready are both 1. req_ready stays 0 from acceptance until the response. rsp_valid is a single-cycle pulse. A request presented while the engine is busy is ignored and produces no response.
- R10: Range and target writes take effect only while req_ready is 1. Writes presented during a scan are dropped.
- R11: rsp_steer, rsp_group, rsp_inst and the warning flags keep their values from one response until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Register address to classify |
| req_ready | output | 1 | Engine idle; a request is accepted |
| rsp_valid | output | 1 | One-cycle pulse: response fields are new |
| rsp_steer | output | 1 | 1 = steer to the given group/instance, 0 = no steering needed |
| rsp_group | output | GRP_W | Steering group |
| rsp_inst | output | INST_W | Steering instance |
| rsp_warn_uninit | output | 1 | Hit in a class whose initialized flag is clear |
| rsp_warn_notfound | output | 1 | No range matched; default 0/0 returned |
| cfg_rng_we | input | 1 | Range entry write strobe |
| cfg_rng_cls | input | CLS_W | Class index of the entry (NUM_CLASSES = implicit) |
| cfg_rng_slot | input | SLOT_W | Entry position in the class list |
| cfg_rng_lo | input | ADDR_W | Inclusive lower bound |
| cfg_rng_hi | input | ADDR_W | Inclusive upper bound (0 = list end) |
| cfg_tgt_we | input | 1 | Target write strobe |
| cfg_tgt_cls | input | CLS_W | Normal class whose target is written |
| cfg_tgt_group | input | GRP_W | Group target |
| cfg_tgt_inst | input | INST_W | Instance target |
| cls_init | input | NUM_CLASSES | Per-class initialized flags |

## Verification
Configuration writes and an ongoing scan can land in the same cycle. The same holds for a new request and an ongoing scan. The bench provokes both during a long not-found scan of thirteen entries. In the middle of that scan it writes a new target and a new range into class 0, and it also holds a different request address for two cycles. It judges the outcome from the ports alone. The scan must still report not-found, and exactly one response pulse must appear. Later lookups must show that class 0 keeps its old target, and that the dropped range never matches.

// File: rtl/steer_pkg.sv
package steer_pkg;

    localparam int DEF_NUM_CLASSES = 4;
    localparam int DEF_RANGES      = 4;
    localparam int DEF_ADDR_W      = 24;
    localparam int DEF_GRP_W       = 4;
    localparam int DEF_INST_W      = 4;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } scan_phase_e;

    typedef struct packed {
        logic steer;
        logic warn_uninit;
        logic warn_notfound;
    } rsp_flags_t;

endpackage

// File: rtl/steer_range_cmp.sv
module steer_range_cmp #(
    parameter int ADDR_W = steer_pkg::DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] lo,
    input  logic [ADDR_W-1:0] hi,
    output logic              hit,
    output logic              term
);
    // an upper bound of zero closes the list; it never matches
    always_comb begin
        term = (hi == '0);
        hit  = !term && (addr >= lo) && (addr <= hi);
    end
endmodule

// File: rtl/steer_range_store.sv
module steer_range_store #(
    parameter int NUM_CLASSES = steer_pkg::DEF_NUM_CLASSES,
    parameter int RANGES      = steer_pkg::DEF_RANGES,
    parameter int ADDR_W      = steer_pkg::DEF_ADDR_W,
    parameter int GRP_W       = steer_pkg::DEF_GRP_W,
    parameter int INST_W      = steer_pkg::DEF_INST_W,
    localparam int NUM_SETS   = NUM_CLASSES + 1,
    localparam int CLS_W      = $clog2(NUM_SETS),
    localparam int SLOT_W     = $clog2(RANGES),
    localparam int TGT_W      = GRP_W + INST_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rng_we,
    input  logic [CLS_W-1:0]  rng_cls,
    input  logic [SLOT_W-1:0] rng_slot,
    input  logic [ADDR_W-1:0] rng_lo,
    input  logic [ADDR_W-1:0] rng_hi,
    input  logic              tgt_we,
    input  logic [CLS_W-1:0]  tgt_cls,
    input  logic [GRP_W-1:0]  tgt_group,
    input  logic [INST_W-1:0] tgt_inst,
    input  logic [CLS_W-1:0]  rd_cls,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [ADDR_W-1:0] rd_lo,
    output logic [ADDR_W-1:0] rd_hi,
    output logic [GRP_W-1:0]  rd_group,
    output logic [INST_W-1:0] rd_inst
);
    logic [ADDR_W-1:0] lo_q [NUM_SETS][RANGES];
    logic [ADDR_W-1:0] lo_d [NUM_SETS][RANGES];
    logic [ADDR_W-1:0] hi_q [NUM_SETS][RANGES];
    logic [ADDR_W-1:0] hi_d [NUM_SETS][RANGES];

    always_comb begin
        lo_d = lo_q;
        hi_d = hi_q;
        if (rng_we && (int'(rng_cls) < NUM_SETS)) begin
            lo_d[rng_cls][rng_slot] = rng_lo;
            hi_d[rng_cls][rng_slot] = rng_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int r = 0; r < RANGES; r++) begin
                    lo_q[s][r] <= '0;
                    hi_q[s][r] <= '0;
                end
            end
        end else begin
            lo_q <= lo_d;
            hi_q <= hi_d;
        end
    end

    assign rd_lo = lo_q[rd_cls][rd_slot];
    assign rd_hi = hi_q[rd_cls][rd_slot];

    // one target register per normal class
    logic [NUM_CLASSES*TGT_W-1:0] tgt_flat;

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_tgt
        logic [TGT_W-1:0] t_q;
        logic [TGT_W-1:0] t_d;

        always_comb begin
            t_d = t_q;
            if (tgt_we && (tgt_cls == CLS_W'(c))) begin
                t_d = {tgt_group, tgt_inst};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) t_q <= '0;
            else        t_q <= t_d;
        end

        assign tgt_flat[c*TGT_W +: TGT_W] = t_q;
    end

    logic [TGT_W-1:0] tgt_sel;

    always_comb begin
        tgt_sel = '0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (rd_cls == CLS_W'(c)) tgt_sel = tgt_flat[c*TGT_W +: TGT_W];
        end
    end

    assign rd_group = tgt_sel[TGT_W-1:INST_W];
    assign rd_inst  = tgt_sel[INST_W-1:0];
endmodule

// File: rtl/steer_scan_fsm.sv
module steer_scan_fsm #(
    parameter int NUM_CLASSES = steer_pkg::DEF_NUM_CLASSES,
    parameter int RANGES      = steer_pkg::DEF_RANGES,
    parameter int ADDR_W      = steer_pkg::DEF_ADDR_W,
    parameter int GRP_W       = steer_pkg::DEF_GRP_W,
    parameter int INST_W      = steer_pkg::DEF_INST_W,
    localparam int CLS_W      = $clog2(NUM_CLASSES + 1),
    localparam int SLOT_W     = $clog2(RANGES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic                   ent_hit,
    input  logic                   ent_term,
    input  logic [GRP_W-1:0]       tgt_group,
    input  logic [INST_W-1:0]      tgt_inst,
    input  logic [NUM_CLASSES-1:0] cls_init,
    output logic [ADDR_W-1:0]      scan_addr,
    output logic [CLS_W-1:0]       scan_cls,
    output logic [SLOT_W-1:0]      scan_slot,
    output logic                   idle,
    output logic                   rsp_valid,
    output logic [GRP_W-1:0]       rsp_group,
    output logic [INST_W-1:0]      rsp_inst,
    output steer_pkg::rsp_flags_t  rsp_flags
);
    import steer_pkg::*;

    localparam logic [CLS_W-1:0]  IMPL_CLS  = CLS_W'(NUM_CLASSES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(RANGES - 1);

    typedef struct packed {
        scan_phase_e       phase;
        logic [ADDR_W-1:0] addr;
        logic [CLS_W-1:0]  cls;
        logic [SLOT_W-1:0] slot;
        logic              vld;
        logic [GRP_W-1:0]  grp;
        logic [INST_W-1:0] inst;
        rsp_flags_t        flags;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic     init_sel;
    logic     in_impl;
    logic     list_done;

    always_comb begin
        init_sel = 1'b0;
        for (int c = 0; c < NUM_CLASSES; c++) begin
            if (st_q.cls == CLS_W'(c)) init_sel = cls_init[c];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        in_impl   = (st_q.cls == IMPL_CLS);
        list_done = ent_term || (st_q.slot == LAST_SLOT);

        if (st_q.phase == PH_IDLE) begin
            if (req_valid) begin
                st_d.phase = PH_SCAN;
                st_d.addr  = req_addr;
                st_d.cls   = '0;
                st_d.slot  = '0;
            end
        end else if (ent_hit) begin
            st_d.phase = PH_IDLE;
            st_d.vld   = 1'b1;
            if (in_impl) begin
                st_d.grp   = '0;
                st_d.inst  = '0;
                st_d.flags = '{steer: 1'b0, warn_uninit: 1'b0, warn_notfound: 1'b0};
            end else begin
                st_d.grp   = tgt_group;
                st_d.inst  = tgt_inst;
                st_d.flags = '{steer: 1'b1, warn_uninit: !init_sel, warn_notfound: 1'b0};
            end
        end else if (list_done) begin
            if (in_impl) begin
                st_d.phase = PH_IDLE;
                st_d.vld   = 1'b1;
                st_d.grp   = '0;
                st_d.inst  = '0;
                st_d.flags = '{steer: 1'b1, warn_uninit: 1'b0, warn_notfound: 1'b1};
            end else begin
                st_d.cls  = st_q.cls + CLS_W'(1);
                st_d.slot = '0;
            end
        end else begin
            st_d.slot = st_q.slot + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_addr = st_q.addr;
    assign scan_cls  = st_q.cls;
    assign scan_slot = st_q.slot;
    assign idle      = (st_q.phase == PH_IDLE);
    assign rsp_valid = st_q.vld;
    assign rsp_group = st_q.grp;
    assign rsp_inst  = st_q.inst;
    assign rsp_flags = st_q.flags;
endmodule

// File: rtl/steer_classifier.sv
module steer_classifier #(
    parameter int NUM_CLASSES = steer_pkg::DEF_NUM_CLASSES,
    parameter int RANGES      = steer_pkg::DEF_RANGES,
    parameter int ADDR_W      = steer_pkg::DEF_ADDR_W,
    parameter int GRP_W       = steer_pkg::DEF_GRP_W,
    parameter int INST_W      = steer_pkg::DEF_INST_W,
    localparam int CLS_W      = $clog2(NUM_CLASSES + 1),
    localparam int SLOT_W     = $clog2(RANGES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   req_ready,
    output logic                   rsp_valid,
    output logic                   rsp_steer,
    output logic [GRP_W-1:0]       rsp_group,
    output logic [INST_W-1:0]      rsp_inst,
    output logic                   rsp_warn_uninit,
    output logic                   rsp_warn_notfound,
    input  logic                   cfg_rng_we,
    input  logic [CLS_W-1:0]       cfg_rng_cls,
    input  logic [SLOT_W-1:0]      cfg_rng_slot,
    input  logic [ADDR_W-1:0]      cfg_rng_lo,
    input  logic [ADDR_W-1:0]      cfg_rng_hi,
    input  logic                   cfg_tgt_we,
    input  logic [CLS_W-1:0]       cfg_tgt_cls,
    input  logic [GRP_W-1:0]       cfg_tgt_group,
    input  logic [INST_W-1:0]      cfg_tgt_inst,
    input  logic [NUM_CLASSES-1:0] cls_init
);
    logic [ADDR_W-1:0]     scan_addr;
    logic [CLS_W-1:0]      scan_cls;
    logic [SLOT_W-1:0]     scan_slot;
    logic [ADDR_W-1:0]     ent_lo;
    logic [ADDR_W-1:0]     ent_hi;
    logic                  ent_hit;
    logic                  ent_term;
    logic [GRP_W-1:0]      sel_group;
    logic [INST_W-1:0]     sel_inst;
    logic                  idle;
    steer_pkg::rsp_flags_t flags;

    // configuration only lands while no scan is reading the tables
    steer_range_store #(
        .NUM_CLASSES(NUM_CLASSES), .RANGES(RANGES), .ADDR_W(ADDR_W),
        .GRP_W(GRP_W), .INST_W(INST_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rng_we   (cfg_rng_we && idle),
        .rng_cls  (cfg_rng_cls),
        .rng_slot (cfg_rng_slot),
        .rng_lo   (cfg_rng_lo),
        .rng_hi   (cfg_rng_hi),
        .tgt_we   (cfg_tgt_we && idle),
        .tgt_cls  (cfg_tgt_cls),
        .tgt_group(cfg_tgt_group),
        .tgt_inst (cfg_tgt_inst),
        .rd_cls   (scan_cls),
        .rd_slot  (scan_slot),
        .rd_lo    (ent_lo),
        .rd_hi    (ent_hi),
        .rd_group (sel_group),
        .rd_inst  (sel_inst)
    );

    steer_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .addr(scan_addr),
        .lo  (ent_lo),
        .hi  (ent_hi),
        .hit (ent_hit),
        .term(ent_term)
    );

    steer_scan_fsm #(
        .NUM_CLASSES(NUM_CLASSES), .RANGES(RANGES), .ADDR_W(ADDR_W),
        .GRP_W(GRP_W), .INST_W(INST_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_addr (req_addr),
        .ent_hit  (ent_hit),
        .ent_term (ent_term),
        .tgt_group(sel_group),
        .tgt_inst (sel_inst),
        .cls_init (cls_init),
        .scan_addr(scan_addr),
        .scan_cls (scan_cls),
        .scan_slot(scan_slot),
        .idle     (idle),
        .rsp_valid(rsp_valid),
        .rsp_group(rsp_group),
        .rsp_inst (rsp_inst),
        .rsp_flags(flags)
    );

    assign req_ready         = idle;
    assign rsp_steer         = flags.steer;
    assign rsp_warn_uninit   = flags.warn_uninit;
    assign rsp_warn_notfound = flags.warn_notfound;
endmodule

// File: rtl/steer_classifier_chk.sv
module steer_classifier_chk #(
    parameter int GRP_W  = steer_pkg::DEF_GRP_W,
    parameter int INST_W = steer_pkg::DEF_INST_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_steer,
    input logic [GRP_W-1:0]  rsp_group,
    input logic [INST_W-1:0] rsp_inst,
    input logic              rsp_warn_uninit,
    input logic              rsp_warn_notfound
);
    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !rsp_valid));

    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_idle_at_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    p_notfound_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_warn_notfound) |-> (rsp_steer && rsp_group == '0 && rsp_inst == '0));

    p_implicit_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_steer) |->
            (rsp_group == '0 && rsp_inst == '0 && !rsp_warn_uninit && !rsp_warn_notfound));

    p_uninit_steers_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_warn_uninit) |-> (rsp_steer && !rsp_warn_notfound));

    p_hold_between_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> ($stable(rsp_steer) && $stable(rsp_group) && $stable(rsp_inst)
                        && $stable(rsp_warn_uninit) && $stable(rsp_warn_notfound)));
endmodule

bind steer_classifier steer_classifier_chk #(.GRP_W(GRP_W), .INST_W(INST_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .req_ready        (req_ready),
    .rsp_valid        (rsp_valid),
    .rsp_steer        (rsp_steer),
    .rsp_group        (rsp_group),
    .rsp_inst         (rsp_inst),
    .rsp_warn_uninit  (rsp_warn_uninit),
    .rsp_warn_notfound(rsp_warn_notfound)
);

// File: tb/steer_classifier_tb_top.sv
`timescale 1ns/1ps
module steer_classifier_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_steer;
    logic [3:0]  rsp_group;
    logic [3:0]  rsp_inst;
    logic        rsp_warn_uninit;
    logic        rsp_warn_notfound;
    logic        cfg_rng_we = 1'b0;
    logic [2:0]  cfg_rng_cls = '0;
    logic [1:0]  cfg_rng_slot = '0;
    logic [23:0] cfg_rng_lo = '0;
    logic [23:0] cfg_rng_hi = '0;
    logic        cfg_tgt_we = 1'b0;
    logic [2:0]  cfg_tgt_cls = '0;
    logic [3:0]  cfg_tgt_group = '0;
    logic [3:0]  cfg_tgt_inst = '0;
    logic [3:0]  cls_init = 4'b0111;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    steer_classifier dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_steer(rsp_steer), .rsp_group(rsp_group),
        .rsp_inst(rsp_inst), .rsp_warn_uninit(rsp_warn_uninit),
        .rsp_warn_notfound(rsp_warn_notfound),
        .cfg_rng_we(cfg_rng_we), .cfg_rng_cls(cfg_rng_cls), .cfg_rng_slot(cfg_rng_slot),
        .cfg_rng_lo(cfg_rng_lo), .cfg_rng_hi(cfg_rng_hi),
        .cfg_tgt_we(cfg_tgt_we), .cfg_tgt_cls(cfg_tgt_cls),
        .cfg_tgt_group(cfg_tgt_group), .cfg_tgt_inst(cfg_tgt_inst),
        .cls_init(cls_init)
    );

    typedef struct packed {
        logic [23:0] addr;
        logic        steer;
        logic [3:0]  grp;
        logic [3:0]  inst;
        logic        un;
        logic        nf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{24'h001000, 1'b1, 4'd1, 4'd2, 1'b0, 1'b0, 8'd3},  // R3 lower bound
        '{24'h0010FF, 1'b1, 4'd1, 4'd2, 1'b0, 1'b0, 8'd3},  // R3 upper bound
        '{24'h000FFF, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1, 8'd3},  // R3 below
        '{24'h002000, 1'b1, 4'd1, 4'd2, 1'b0, 1'b0, 8'd3},  // R3 single address
        '{24'h002001, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1, 8'd3},  // R3 above
        '{24'h001080, 1'b1, 4'd1, 4'd2, 1'b0, 1'b0, 8'd2},  // R2 class 0 beats class 2
        '{24'h004050, 1'b1, 4'd5, 4'd3, 1'b0, 1'b0, 8'd2},  // R2 class 2 second slot
        '{24'h004005, 1'b1, 4'd5, 4'd3, 1'b0, 1'b0, 8'd6},  // R6 normal beats implicit
        '{24'h003000, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 8'd4},  // R4 entry after terminator
        '{24'h006000, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1, 8'd5},  // R5 empty class skipped
        '{24'h007080, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 8'd6},  // R6 implicit hit
        '{24'h0070FF, 1'b0, 4'd0, 4'd0, 1'b0, 1'b0, 8'd6},  // R6 implicit upper bound
        '{24'h005000, 1'b1, 4'd7, 4'd0, 1'b1, 1'b0, 8'd8},  // R8 uninitialized class
        '{24'h009000, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1, 8'd7},  // R7 nothing matches
        '{24'h000000, 1'b1, 4'd0, 4'd0, 1'b0, 1'b1, 8'd7}   // R7 address zero
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic set_rng(input int c, input int s, input int lo, input int hi);
        @(negedge clk);
        cfg_rng_we = 1'b1; cfg_rng_cls = 3'(c); cfg_rng_slot = 2'(s);
        cfg_rng_lo = 24'(lo); cfg_rng_hi = 24'(hi);
        @(negedge clk);
        cfg_rng_we = 1'b0;
    endtask

    task automatic set_tgt(input int c, input int g, input int i);
        @(negedge clk);
        cfg_tgt_we = 1'b1; cfg_tgt_cls = 3'(c);
        cfg_tgt_group = 4'(g); cfg_tgt_inst = 4'(i);
        @(negedge clk);
        cfg_tgt_we = 1'b0;
    endtask

    task automatic wait_rsp(input string req);
        int n = 0;
        while (!rsp_valid && n < 500) begin
            @(negedge clk);
            n++;
        end
        if (n >= 500) check(req, "response timeout", 0, 1);
    endtask

    task automatic lookup(input int a, input string req);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'(a);
        @(negedge clk);
        req_valid = 1'b0;
        wait_rsp(req);
    endtask

    task automatic expect_rsp(input string req, input int st, input int g, input int i,
                              input int un, input int nf);
        check(req, "steer", int'(rsp_steer), st);
        check(req, "group", int'(rsp_group), g);
        check(req, "inst", int'(rsp_inst), i);
        check(req, "warn_uninit", int'(rsp_warn_uninit), un);
        check(req, "warn_notfound", int'(rsp_warn_notfound), nf);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check("R1", "req_ready in reset", int'(req_ready), 1);
        check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        expect_rsp("R1", 0, 0, 0, 0, 0);

        // R1 R7 empty tables after reset give not-found
        lookup(32'h1000, "R1");
        expect_rsp("R1", 1, 0, 0, 0, 1);

        // configuration (all writes while idle)
        set_tgt(0, 1, 2); set_tgt(1, 3, 1); set_tgt(2, 5, 3); set_tgt(3, 7, 0);
        set_rng(0, 0, 32'h1000, 32'h10FF);
        set_rng(0, 1, 32'h2000, 32'h2000);
        set_rng(0, 3, 32'h3000, 32'h30FF);   // beyond terminator in slot 2
        set_rng(1, 3, 32'h6000, 32'h60FF);   // class 1 has empty slot 0
        set_rng(2, 0, 32'h1080, 32'h10FF);
        set_rng(2, 1, 32'h4000, 32'h40FF);
        set_rng(3, 0, 32'h5000, 32'h50FF);
        set_rng(4, 0, 32'h7000, 32'h70FF);   // implicit class
        set_rng(4, 1, 32'h4000, 32'h4010);
        set_rng(4, 2, 32'h3000, 32'h30FF);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            lookup(int'(VECS[k].addr), tag);
            expect_rsp(tag, int'(VECS[k].steer), int'(VECS[k].grp), int'(VECS[k].inst),
                       int'(VECS[k].un), int'(VECS[k].nf));
        end

        // R9 busy engine ignores a second request
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h009000;
        @(negedge clk);
        check("R9", "req_ready while scanning", int'(req_ready), 0);
        req_addr = 24'h001000;
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        wait_rsp("R9");
        expect_rsp("R9", 1, 0, 0, 0, 1);
        @(negedge clk);
        check("R9", "rsp_valid one cycle", int'(rsp_valid), 0);
        begin
            int extra = 0;
            for (int k = 0; k < 30; k++) begin
                if (rsp_valid) extra++;
                @(negedge clk);
            end
            check("R9", "responses for ignored request", extra, 0);
        end
        check("R9", "req_ready after response", int'(req_ready), 1);
        // R11 fields held across idle cycles
        expect_rsp("R11", 1, 0, 0, 0, 1);

        // R10 configuration writes during a scan are dropped
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h009000;
        @(negedge clk);
        req_valid = 1'b0;
        cfg_tgt_we = 1'b1; cfg_tgt_cls = 3'd0; cfg_tgt_group = 4'd9; cfg_tgt_inst = 4'd4;
        cfg_rng_we = 1'b1; cfg_rng_cls = 3'd0; cfg_rng_slot = 2'd2;
        cfg_rng_lo = 24'h008000; cfg_rng_hi = 24'h0080FF;
        @(negedge clk);
        cfg_tgt_we = 1'b0; cfg_rng_we = 1'b0;
        wait_rsp("R10");
        expect_rsp("R10", 1, 0, 0, 0, 1);
        lookup(32'h1000, "R10");
        expect_rsp("R10", 1, 1, 2, 0, 0);
        lookup(32'h8000, "R10");
        expect_rsp("R10", 1, 0, 0, 0, 1);
        // R10 same write while idle takes effect
        set_tgt(0, 9, 4);
        lookup(32'h1000, "R10");
        expect_rsp("R10", 1, 9, 4, 0, 0);

        // R8 setting the init flag clears the warning
        cls_init = 4'b1111;
        lookup(32'h50FF, "R8");
        expect_rsp("R8", 1, 7, 0, 0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule